// File: doc/BRIEF.md
# Clock-Synthesizer Configuration Port over I2C

This block is the two-wire configuration target of a clock-synthesizer controller. A host on an I2C bus addresses it with a 7-bit target address. The lowest bit of that address comes from a strap input, so two such controllers can share one bus. The host writes and reads a small bank of byte-wide configuration registers. It can move one byte per transaction or a burst, and the register index steps forward after every byte. Reads begin with a write phase that carries the index, followed by a repeated START with the read bit set.

Part of the configuration must not disturb a running loop halfway through an update. Those registers are double-buffered. The host writes a staging copy, which reads back at once. The working copy that drives the outputs changes only when a coded value is written to a command register. One nibble of that value commits the loop group (loop control and the 12-bit feedback divider). The other nibble commits the phase-step resolution register. The two groups can be committed separately or together.

Identification and lock-status registers are read-only. The lock flags arrive as input signals and are resynchronised to the system clock. SCL and SDA are oversampled by the system clock. SDA is driven only as an open-drain low.

Top module: `synth_cfg_i2c`

## Requirements
- R1: The device answers only the 7-bit address 010011S, where S is the level of `addr_sel`; the write byte is 0x4C (S=0) or 0x4E (S=1) and the read byte adds 1. A byte carrying any other address gets no ACK (SDA stays high in the ninth clock), and the rest of that transaction changes nothing.
- R2: A write transaction (START, address with R/W=0, index, data, STOP) stores the data byte at the index, and the device ACKs each of the three bytes.
- R3: Further data bytes in the same write transaction go to consecutive indices, and each one is ACKed.
- R4: A read is START, address with R/W=0, index, repeated START, address with R/W=1, then one data byte driven MSB first. A host NACK ends the transfer.
- R5: In a read, each host ACK makes the device send the byte at the next index.
- R6: After reset, the register values are: index 0 = 0x41, index 1 = 0x00, index 2 = 0xFF, index 3 = 0x0F, index 4 = 0x80, index 5 = 0x03, index 6 = 0x00, index 7 = 0x80. The working outputs carry the same values.
- R7: Indices 1, 2 and 3 are staged. A write to them reads back at once, but `cfg_loop` and `cfg_fbdiv` ({index 3 bits 3:0, index 2}) change only when index 8 is written with upper nibble 0x5.
- R8: Index 5 is staged. `cfg_phase_res` takes the staged value only when index 8 is written with lower nibble 0xA, and that write leaves the loop group alone. The value 0x5A commits both groups.
- R9: Index 0x10 reads the version constant (default 0x18) and index 0x11 reads the revision constant (default 0x01). Index 0x12 reads {6'b0, `pll_lock`, `phase_lock`}, with phase lock in bit 0 and PLL lock in bit 1.
- R10: Index 8 reads 0x00, unimplemented indices read 0x00, and bits 7:4 of index 3 read 0. Writes to read-only or unimplemented indices are ACKed and have no effect.
- R11: `sda_oe` is asserted only in an ACK slot or while a 0 data bit is being returned, and it is low after every STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| addr_sel | input | 1 | Strap for the lowest bit of the target address |
| pll_lock | input | 1 | PLL lock flag, asynchronous |
| phase_lock | input | 1 | Phase-adjust lock flag, asynchronous |
| cfg_ctrl | output | 8 | Input-control register (index 0) |
| cfg_loop | output | 8 | Working loop-control register |
| cfg_fbdiv | output | 12 | Working feedback divider value |
| cfg_phase_ofs | output | 8 | Phase offset and filter select (index 4) |
| cfg_phase_res | output | 8 | Working phase-step resolution register |
| cfg_out_en | output | 8 | Output enable and scaler register (index 6) |
| cfg_osc_div | output | 8 | Oscillator divider register (index 7) |

## Verification
Bus levels pass through a two-flop synchroniser and an edge detector. As a result, the device changes SDA about three system clocks after SCL falls, and it stores a written byte one clock after it decides the ACK. A commit reaches the working outputs one clock after the command byte is stored. The bench moves the bus with a quarter-period of eight system clocks. It reads ACK and data bits half a high phase after SCL rises, when the device has long since settled. It checks the configuration outputs only after the STOP, well past the strobe and the commit clock.

// File: rtl/i2ccfg_pkg.sv
package i2ccfg_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_CW = $clog2(BYTE_W);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_INDEX,
    ST_INDEX_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK
  } bus_state_t;

  localparam logic [7:0] IDX_CTRL  = 8'h00;
  localparam logic [7:0] IDX_LOOP  = 8'h01;
  localparam logic [7:0] IDX_FBLO  = 8'h02;
  localparam logic [7:0] IDX_FBHI  = 8'h03;
  localparam logic [7:0] IDX_PHOFS = 8'h04;
  localparam logic [7:0] IDX_PHRES = 8'h05;
  localparam logic [7:0] IDX_OUTEN = 8'h06;
  localparam logic [7:0] IDX_OSC   = 8'h07;
  localparam logic [7:0] IDX_CMD   = 8'h08;
  localparam logic [7:0] IDX_VER   = 8'h10;
  localparam logic [7:0] IDX_REV   = 8'h11;
  localparam logic [7:0] IDX_STAT  = 8'h12;

  localparam logic [7:0] RST_CTRL  = 8'h41;
  localparam logic [7:0] RST_LOOP  = 8'h00;
  localparam logic [7:0] RST_FBLO  = 8'hFF;
  localparam logic [7:0] RST_PHOFS = 8'h80;
  localparam logic [7:0] RST_PHRES = 8'h03;
  localparam logic [7:0] RST_OUTEN = 8'h00;
  localparam logic [7:0] RST_OSC   = 8'h80;

  localparam logic [3:0] CMD_LOOP_NIB  = 4'h5;
  localparam logic [3:0] CMD_PHASE_NIB = 4'hA;
endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH = 1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= {WIDTH{RST_VAL}};
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s - 1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_bus_engine.sv
module i2c_bus_engine
  import i2ccfg_pkg::*;
#(
  parameter logic [5:0] ADDR_HI = 6'b010011,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] rd_idx,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe
);
  logic scl_s, sda_s, scl_d, sda_d;
  logic scl_rise, scl_fall, start_det, stop_det;
  bus_state_t state;
  logic [BIT_CW-1:0] cnt;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] ptr;
  logic got, rw;

  line_sync #(.STAGES(SYNC_STAGES), .WIDTH(2), .RST_VAL(1'b1)) u_bus_sync (
    .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q({scl_s, sda_s})
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  assign rd_idx    = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      ptr     <= '0;
      got     <= 1'b0;
      rw      <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        got    <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        got    <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_INDEX, ST_WDATA: begin
            if (scl_rise) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
              if (cnt == BIT_CW'(BYTE_W - 1)) got <= 1'b1;
            end else if (scl_fall && got) begin
              got <= 1'b0;
              cnt <= '0;
              if (state == ST_ADDR) begin
                if (sh[7:1] == {ADDR_HI, addr_sel}) begin
                  rw     <= sh[0];
                  sda_oe <= 1'b1;
                  state  <= ST_ADDR_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_INDEX) begin
                ptr    <= sh;
                sda_oe <= 1'b1;
                state  <= ST_INDEX_ACK;
              end else begin
                wr_en   <= 1'b1;
                wr_idx  <= ptr;
                wr_data <= sh;
                ptr     <= ptr + 1'b1;
                sda_oe  <= 1'b1;
                state   <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                sh     <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                ptr    <= ptr + 1'b1;
                state  <= ST_RDATA;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_INDEX;
              end
            end
          end
          ST_INDEX_ACK, ST_WDATA_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
              if (cnt == BIT_CW'(BYTE_W - 1)) got <= 1'b1;
            end else if (scl_fall) begin
              if (got) begin
                got    <= 1'b0;
                sda_oe <= 1'b0;
                state  <= ST_RDATA_ACK;
              end else begin
                sh     <= {sh[BYTE_W-2:0], 1'b0};
                sda_oe <= ~sh[BYTE_W-2];
              end
            end
          end
          ST_RDATA_ACK: begin
            if (scl_rise) begin
              if (sda_s) state <= ST_IDLE;
              else got <= 1'b1;
            end else if (scl_fall && got) begin
              got    <= 1'b0;
              cnt    <= '0;
              sh     <= rd_data;
              sda_oe <= ~rd_data[BYTE_W-1];
              ptr    <= ptr + 1'b1;
              state  <= ST_RDATA;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R11: SDA is released in every state that neither acknowledges nor returns data
  assert_sda_released_R11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE || state == ST_ADDR || state == ST_INDEX ||
     state == ST_WDATA || state == ST_RDATA_ACK) |-> !sda_oe);

  // R2: a store strobe lasts exactly one cycle per data byte
  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  // R1: a matching address is always followed by an acknowledge slot driving SDA low
  assert_addr_ack_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADDR && $past(state) == ST_ADDR && got && scl_fall && !start_det && !stop_det &&
     sh[7:1] == {ADDR_HI, addr_sel}) |=> (sda_oe && state == ST_ADDR_ACK));
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import i2ccfg_pkg::*;
#(
  parameter int FB_W = 12,
  parameter logic [7:0] VERSION_ID = 8'h18,
  parameter logic [7:0] REVISION_ID = 8'h01,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [BYTE_W-1:0] rd_idx,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              pll_lock_i,
  input  logic              phase_lock_i,
  output logic [7:0]        cfg_ctrl,
  output logic [7:0]        cfg_loop,
  output logic [FB_W-1:0]   cfg_fbdiv,
  output logic [7:0]        cfg_phase_ofs,
  output logic [7:0]        cfg_phase_res,
  output logic [7:0]        cfg_out_en,
  output logic [7:0]        cfg_osc_div
);
  localparam int FBHI_W = FB_W - BYTE_W;
  localparam int FBPAD_W = 2 * BYTE_W - FB_W;

  logic [7:0] stage_loop, stage_fblo, stage_phres;
  logic [FBHI_W-1:0] stage_fbhi;
  logic pll_s, phase_s;
  logic cmd_wr, loop_go, phase_go;

  line_sync #(.STAGES(SYNC_STAGES), .WIDTH(2), .RST_VAL(1'b0)) u_lock_sync (
    .clk(clk), .rst(rst), .d({pll_lock_i, phase_lock_i}), .q({pll_s, phase_s})
  );

  assign cmd_wr   = wr_en && (wr_idx == IDX_CMD);
  assign loop_go  = cmd_wr && (wr_data[7:4] == CMD_LOOP_NIB);
  assign phase_go = cmd_wr && (wr_data[3:0] == CMD_PHASE_NIB);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_ctrl      <= RST_CTRL;
      stage_loop    <= RST_LOOP;
      stage_fblo    <= RST_FBLO;
      stage_fbhi    <= '1;
      cfg_phase_ofs <= RST_PHOFS;
      stage_phres   <= RST_PHRES;
      cfg_out_en    <= RST_OUTEN;
      cfg_osc_div   <= RST_OSC;
    end else if (wr_en) begin
      case (wr_idx)
        IDX_CTRL:  cfg_ctrl      <= wr_data;
        IDX_LOOP:  stage_loop    <= wr_data;
        IDX_FBLO:  stage_fblo    <= wr_data;
        IDX_FBHI:  stage_fbhi    <= wr_data[FBHI_W-1:0];
        IDX_PHOFS: cfg_phase_ofs <= wr_data;
        IDX_PHRES: stage_phres   <= wr_data;
        IDX_OUTEN: cfg_out_en    <= wr_data;
        IDX_OSC:   cfg_osc_div   <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_loop  <= RST_LOOP;
      cfg_fbdiv <= {{FBHI_W{1'b1}}, RST_FBLO};
    end else if (loop_go) begin
      cfg_loop  <= stage_loop;
      cfg_fbdiv <= {stage_fbhi, stage_fblo};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_phase_res <= RST_PHRES;
    else if (phase_go) cfg_phase_res <= stage_phres;
  end

  always_comb begin
    case (rd_idx)
      IDX_CTRL:  rd_data = cfg_ctrl;
      IDX_LOOP:  rd_data = stage_loop;
      IDX_FBLO:  rd_data = stage_fblo;
      IDX_FBHI:  rd_data = {{FBPAD_W{1'b0}}, stage_fbhi};
      IDX_PHOFS: rd_data = cfg_phase_ofs;
      IDX_PHRES: rd_data = stage_phres;
      IDX_OUTEN: rd_data = cfg_out_en;
      IDX_OSC:   rd_data = cfg_osc_div;
      IDX_VER:   rd_data = VERSION_ID;
      IDX_REV:   rd_data = REVISION_ID;
      IDX_STAT:  rd_data = {6'b0, pll_s, phase_s};
      default:   rd_data = '0;
    endcase
  end

  // R7: loop group commit copies the staged values
  assert_loop_commit_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == IDX_CMD && wr_data[7:4] == CMD_LOOP_NIB) |=>
      (cfg_loop == $past(stage_loop) && cfg_fbdiv == {$past(stage_fbhi), $past(stage_fblo)}));

  // R7: without a loop command the working loop group holds
  assert_loop_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_idx == IDX_CMD && wr_data[7:4] == CMD_LOOP_NIB) |=>
      ($stable(cfg_loop) && $stable(cfg_fbdiv)));

  // R8: phase group commit and hold
  assert_phase_commit_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == IDX_CMD && wr_data[3:0] == CMD_PHASE_NIB) |=>
      cfg_phase_res == $past(stage_phres));
  assert_phase_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_idx == IDX_CMD && wr_data[3:0] == CMD_PHASE_NIB) |=> $stable(cfg_phase_res));
endmodule

// File: rtl/synth_cfg_i2c.sv
module synth_cfg_i2c
  import i2ccfg_pkg::*;
#(
  parameter logic [5:0] ADDR_HI = 6'b010011,
  parameter int FB_W = 12,
  parameter logic [7:0] VERSION_ID = 8'h18,
  parameter logic [7:0] REVISION_ID = 8'h01,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe,
  input  logic            addr_sel,
  input  logic            pll_lock,
  input  logic            phase_lock,
  output logic [7:0]      cfg_ctrl,
  output logic [7:0]      cfg_loop,
  output logic [FB_W-1:0] cfg_fbdiv,
  output logic [7:0]      cfg_phase_ofs,
  output logic [7:0]      cfg_phase_res,
  output logic [7:0]      cfg_out_en,
  output logic [7:0]      cfg_osc_div
);
  logic [BYTE_W-1:0] rd_data, rd_idx, wr_idx, wr_data;
  logic wr_en;

  i2c_bus_engine #(.ADDR_HI(ADDR_HI), .SYNC_STAGES(SYNC_STAGES)) u_engine (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .addr_sel(addr_sel),
    .rd_data(rd_data), .rd_idx(rd_idx), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .sda_oe(sda_oe)
  );

  cfg_regbank #(.FB_W(FB_W), .VERSION_ID(VERSION_ID), .REVISION_ID(REVISION_ID),
                .SYNC_STAGES(SYNC_STAGES)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .pll_lock_i(pll_lock), .phase_lock_i(phase_lock),
    .cfg_ctrl(cfg_ctrl), .cfg_loop(cfg_loop), .cfg_fbdiv(cfg_fbdiv),
    .cfg_phase_ofs(cfg_phase_ofs), .cfg_phase_res(cfg_phase_res),
    .cfg_out_en(cfg_out_en), .cfg_osc_div(cfg_osc_div)
  );
endmodule

// File: tb/synth_cfg_i2c_test.sv
`timescale 1ns/1ps
module synth_cfg_i2c_test;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic h_scl = 1'b1, h_sda = 1'b1;
  logic addr_sel = 1'b0, pll_lock = 1'b0, phase_lock = 1'b0;
  logic sda_oe, sda_bus;
  logic [7:0] cfg_ctrl, cfg_loop, cfg_phase_ofs, cfg_phase_res, cfg_out_en, cfg_osc_div;
  logic [11:0] cfg_fbdiv;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;
  assign sda_bus = h_sda & ~sda_oe;

  synth_cfg_i2c uut (
    .clk(clk), .rst(rst), .scl_i(h_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .pll_lock(pll_lock), .phase_lock(phase_lock),
    .cfg_ctrl(cfg_ctrl), .cfg_loop(cfg_loop), .cfg_fbdiv(cfg_fbdiv),
    .cfg_phase_ofs(cfg_phase_ofs), .cfg_phase_res(cfg_phase_res),
    .cfg_out_en(cfg_out_en), .cfg_osc_div(cfg_osc_div)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    tick(2*Q); h_sda = 1'b0; tick(2*Q); h_scl = 1'b0;
  endtask
  task automatic bus_rstart();
    tick(Q); h_sda = 1'b1; tick(Q); h_scl = 1'b1; tick(2*Q); h_sda = 1'b0; tick(2*Q); h_scl = 1'b0;
  endtask
  task automatic bus_stop();
    tick(Q); h_sda = 1'b0; tick(Q); h_scl = 1'b1; tick(2*Q); h_sda = 1'b1; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      tick(Q); h_sda = b[i]; tick(Q); h_scl = 1'b1; tick(2*Q); h_scl = 1'b0;
    end
    tick(Q); h_sda = 1'b1; tick(Q); h_scl = 1'b1; tick(Q); ack = !sda_bus; tick(Q); h_scl = 1'b0;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      tick(Q); h_sda = 1'b1; tick(Q); h_scl = 1'b1; tick(Q); b[i] = sda_bus; tick(Q); h_scl = 1'b0;
    end
    tick(Q); h_sda = nack; tick(Q); h_scl = 1'b1; tick(2*Q); h_scl = 1'b0;
  endtask

  // write n (1..3) bytes from idx; returns number of ACKed bytes
  task automatic wr(input logic [7:0] dev, input logic [7:0] idx, input int n,
                    input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                    output int acks);
    logic a;
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    acks = 0;
    bus_start();
    send_byte(dev, a);
    if (a) begin
      acks++;
      send_byte(idx, a); if (a) acks++;
      for (int k = 0; k < n; k++) begin
        send_byte(d[k], a); if (a) acks++;
      end
    end
    bus_stop();
    tick(4);
  endtask

  task automatic rd(input logic [7:0] dev, input logic [7:0] idx, input int n,
                    output logic [7:0] r0, output logic [7:0] r1, output logic [7:0] r2);
    logic a;
    logic [7:0] r [3];
    r[0] = 8'hxx; r[1] = 8'hxx; r[2] = 8'hxx;
    bus_start();
    send_byte(dev, a);
    send_byte(idx, a);
    bus_rstart();
    send_byte(dev | 8'h01, a);
    for (int k = 0; k < n; k++) recv_byte(k == n - 1, r[k]);
    bus_stop();
    tick(4);
    r0 = r[0]; r1 = r[1]; r2 = r[2];
  endtask

  task automatic t_reset();
    logic [7:0] a, b, c;
    chk("R6 ctrl", cfg_ctrl, 8'h41);
    chk("R6 loop", cfg_loop, 8'h00);
    chk("R6 fbdiv", cfg_fbdiv, 12'hFFF);
    chk("R6 phase_ofs", cfg_phase_ofs, 8'h80);
    chk("R6 phase_res", cfg_phase_res, 8'h03);
    chk("R6 out_en", cfg_out_en, 8'h00);
    chk("R6 osc_div", cfg_osc_div, 8'h80);
    chk("R11 idle release", sda_oe, 1'b0);
    rd(8'h4C, 8'h02, 2, a, b, c);
    chk("R6 idx2 read", a, 8'hFF);
    chk("R6 idx3 read", b, 8'h0F);
  endtask

  task automatic t_address();
    int n;
    logic [7:0] a, b, c;
    addr_sel = 1'b0;
    wr(8'h4E, 8'h00, 1, 8'h55, 8'h00, 8'h00, n);
    chk("R1 foreign address not acked", n, 0);
    chk("R1 foreign write ignored", cfg_ctrl, 8'h41);
    addr_sel = 1'b1;
    tick(4);
    wr(8'h4E, 8'h06, 1, 8'h3C, 8'h00, 8'h00, n);
    chk("R1 strap-high address acked", n, 3);
    chk("R1 strap-high write", cfg_out_en, 8'h3C);
    rd(8'h4E, 8'h06, 1, a, b, c);
    chk("R1 strap-high read", a, 8'h3C);
    addr_sel = 1'b0;
    tick(4);
  endtask

  task automatic t_single_write();
    int n;
    logic [7:0] a, b, c;
    wr(8'h4C, 8'h07, 1, 8'h23, 8'h00, 8'h00, n);
    chk("R2 all bytes acked", n, 3);
    chk("R2 osc_div written", cfg_osc_div, 8'h23);
    chk("R11 released after stop", sda_oe, 1'b0);
    rd(8'h4C, 8'h07, 1, a, b, c);
    chk("R4 MSB-first read", a, 8'h23);
    wr(8'h4C, 8'h00, 1, 8'hA6, 8'h00, 8'h00, n);
    chk("R2 ctrl written", cfg_ctrl, 8'hA6);
  endtask

  task automatic t_loop_group();
    int n;
    logic [7:0] a, b, c;
    wr(8'h4C, 8'h01, 3, 8'h12, 8'h34, 8'h09, n);
    chk("R3 burst acked", n, 5);
    rd(8'h4C, 8'h01, 3, a, b, c);
    chk("R5 staged idx1", a, 8'h12);
    chk("R5 staged idx2", b, 8'h34);
    chk("R5 staged idx3", c, 8'h09);
    chk("R7 loop held", cfg_loop, 8'h00);
    chk("R7 fbdiv held", cfg_fbdiv, 12'hFFF);
    wr(8'h4C, 8'h08, 1, 8'h50, 8'h00, 8'h00, n);
    chk("R7 loop committed", cfg_loop, 8'h12);
    chk("R7 fbdiv committed", cfg_fbdiv, 12'h934);
    chk("R8 res untouched by loop cmd", cfg_phase_res, 8'h03);
  endtask

  task automatic t_phase_group();
    int n;
    wr(8'h4C, 8'h05, 1, 8'h01, 8'h00, 8'h00, n);
    wr(8'h4C, 8'h01, 1, 8'h77, 8'h00, 8'h00, n);
    chk("R8 res held while staged", cfg_phase_res, 8'h03);
    wr(8'h4C, 8'h08, 1, 8'h0A, 8'h00, 8'h00, n);
    chk("R8 res committed", cfg_phase_res, 8'h01);
    chk("R8 loop untouched by phase cmd", cfg_loop, 8'h12);
    wr(8'h4C, 8'h05, 1, 8'h02, 8'h00, 8'h00, n);
    wr(8'h4C, 8'h08, 1, 8'h5A, 8'h00, 8'h00, n);
    chk("R8 both committed res", cfg_phase_res, 8'h02);
    chk("R8 both committed loop", cfg_loop, 8'h77);
  endtask

  task automatic t_ident();
    logic [7:0] a, b, c;
    pll_lock = 1'b1; phase_lock = 1'b0;
    tick(8);
    rd(8'h4C, 8'h12, 1, a, b, c);
    chk("R9 status pll only", a, 8'h02);
    pll_lock = 1'b0; phase_lock = 1'b1;
    tick(8);
    rd(8'h4C, 8'h10, 3, a, b, c);
    chk("R9 version", a, 8'h18);
    chk("R9 revision", b, 8'h01);
    chk("R9 status phase only", c, 8'h01);
  endtask

  task automatic t_ignored();
    int n;
    logic [7:0] a, b, c;
    wr(8'h4C, 8'h10, 1, 8'hAA, 8'h00, 8'h00, n);
    chk("R10 read-only write acked", n, 3);
    rd(8'h4C, 8'h10, 1, a, b, c);
    chk("R10 version unchanged", a, 8'h18);
    rd(8'h4C, 8'h08, 1, a, b, c);
    chk("R10 command reads zero", a, 8'h00);
    wr(8'h4C, 8'h20, 1, 8'hC3, 8'h00, 8'h00, n);
    rd(8'h4C, 8'h20, 1, a, b, c);
    chk("R10 unimplemented reads zero", a, 8'h00);
    wr(8'h4C, 8'h03, 1, 8'hF5, 8'h00, 8'h00, n);
    rd(8'h4C, 8'h03, 1, a, b, c);
    chk("R10 idx3 upper nibble zero", a, 8'h05);
    chk("R11 released at end", sda_oe, 1'b0);
  endtask

  initial begin
    tick(10);
    rst = 1'b0;
    tick(10);
    t_reset();
    t_address();
    t_single_write();
    t_loop_group();
    t_phase_group();
    t_ident();
    t_ignored();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule